// File: doc/BRIEF.md
# Bus Controller Status Response Checker

This block sits beside the bus-controller message sequencer of a dual-redundant serial command/response bus. When a message starts, it takes that message's control word and the commanded terminal addresses. From the control word it decodes the bus to use, the self-test request, the mode-code marking, and how the message ends. It then watches the status words that come back as a valid-strobed 16-bit input and checks each one against what the control word says should happen.

Errors build up over the whole message. When checking finishes, the block reports them in a one-cycle pulse, together with a done strobe. Broadcast messages expect no status at all and finish when the sequencer signals the end of the message. An RT-to-RT transfer expects two status responses and validates both of them. A missing response is reported when the sequencer ends the message early.

The controller is built as one state machine with five states:
- `ST_IDLE`: waiting for a message. It goes to `ST_BCAST_OPEN` on a broadcast start, or to `ST_WAIT_FIRST` on any other start.
- `ST_WAIT_FIRST`: waiting for the first status word. A status moves it to `ST_WAIT_SECOND` for RT-to-RT, or to `ST_REPORT` otherwise. An end-of-message moves it to `ST_REPORT`.
- `ST_WAIT_SECOND`: waiting for the second status word. A status or an end-of-message moves it to `ST_REPORT`.
- `ST_BCAST_OPEN`: the broadcast window. An end-of-message moves it to `ST_REPORT`.
- `ST_REPORT`: always returns to `ST_IDLE` on the next clock.

Top module: `bc_status_checker`

## Requirements
- R1: After reset, every output is 0 and the checker is idle.
- R2: In the cycle after an accepted `msg_start`, the outputs take these values from the control word, and hold them until the next accepted start:
  - `bus_a_o` = control bit 7 (1 selects bus A, 0 selects bus B).
  - `selftest_o` = bit 5.
  - `mode_code_o` = bit 2.
  - `mode_type_o` = `cmd_wc` when bit 2 is 1, else 0.
  Control bits 15:8, 6 and 3 have no effect.
- R3: For a message that is neither broadcast (bit 1) nor RT-to-RT (bit 0), `done_o` pulses in the cycle after the cycle in which `sts_valid` is sampled high.
- R4: The status bit 4 (broadcast received) is compared with the mask-broadcast control bit 4:
  - Mask 0 with status bit 4 set gives `sts_set_err_o`.
  - Mask 1 with status bit 4 clear gives `fmt_err_o` instead.
  - Equal values give neither error.
- R5: A status word whose bits 15:11 differ from the expected terminal address gives `fmt_err_o`.
- R6: For RT-to-RT (bit 0 = 1), two status words are expected. The first is checked against `cmd_rt_addr2` and the second against `cmd_rt_addr`. `done_o` pulses after the second, and errors from either status are reported.
- R7: For broadcast (bit 1 = 1), the message finishes in the cycle after `msg_end`. Any status word received before that gives `fmt_err_o`, and `sts_set_err_o` stays 0.
- R8: If `msg_end` arrives before all expected status words of a non-broadcast message, the message finishes with `fmt_err_o`.
- R9: `sts_set_err_o` and `fmt_err_o` are only high together with `done_o`, and `done_o` is high for exactly one cycle per message.
- R10: A `msg_start` arriving while a message is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_start | input | 1 | Start of a message; samples the control inputs |
| ctrl_word | input | 16 | Per-message control word |
| cmd_rt_addr | input | 5 | Terminal address of the first command word |
| cmd_rt_addr2 | input | 5 | Terminal address of the second command word (RT-to-RT) |
| cmd_wc | input | 5 | Word-count/mode field of the command word |
| sts_valid | input | 1 | Status word strobe |
| sts_word | input | 16 | Returned status word |
| msg_end | input | 1 | Sequencer signals end of the message |
| bus_a_o | output | 1 | 1 = bus A, 0 = bus B |
| selftest_o | output | 1 | Off-line loopback test requested |
| mode_code_o | output | 1 | Message is a mode code |
| mode_type_o | output | 5 | Mode code type when marked |
| done_o | output | 1 | Checking finished (one-cycle pulse) |
| sts_set_err_o | output | 1 | Status-set error pulse |
| fmt_err_o | output | 1 | Format error pulse |

## Verification
The bench tries all four pairings of the mask bit and the broadcast-received bit, which separates the status-set error from the format error. It then runs matching and mismatching terminal addresses on the first and the second status of an RT-to-RT transfer, which shows whether each address is checked against the proper command. Broadcast windows are run with zero, one and two stray status words, and messages are ended with missing responses, to tell the end-by-strobe path from the end-by-status path. Random control words with noise in the unused bits, and random status words, cover the remaining mixes.

// File: rtl/bcsc_pkg.sv
package bcsc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_FIRST,
        ST_WAIT_SECOND,
        ST_BCAST_OPEN,
        ST_REPORT
    } bcsc_state_e;

    // Decoded per-message settings
    typedef struct packed {
        logic bus_a;
        logic selftest;
        logic mask_bc;
        logic mode_code;
        logic bcast;
        logic rtrt;
    } msg_cfg_t;

endpackage

// File: rtl/bcsc_ctrl_decode.sv
module bcsc_ctrl_decode
    import bcsc_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int POS_BUS   = 7,
    parameter int POS_TEST  = 5,
    parameter int POS_MASK  = 4,
    parameter int POS_MODE  = 2,
    parameter int POS_BCAST = 1,
    parameter int POS_RTRT  = 0
) (
    input  logic [WORD_W-1:0] ctrl_word,
    output msg_cfg_t          cfg
);
    always_comb begin
        cfg.bus_a     = ctrl_word[POS_BUS];
        cfg.selftest  = ctrl_word[POS_TEST];
        cfg.mask_bc   = ctrl_word[POS_MASK];
        cfg.mode_code = ctrl_word[POS_MODE];
        cfg.bcast     = ctrl_word[POS_BCAST];
        cfg.rtrt      = ctrl_word[POS_RTRT];
    end
endmodule

// File: rtl/bcsc_sts_eval.sv
module bcsc_sts_eval #(
    parameter int WORD_W   = 16,
    parameter int ADDR_W   = 5,
    parameter int POS_BRCV = 4
) (
    input  logic [WORD_W-1:0] sts_word,
    input  logic [ADDR_W-1:0] exp_addr,
    input  logic              mask_bc,
    output logic              set_err,
    output logic              fmt_err
);
    localparam int ADDR_LSB = WORD_W - ADDR_W;

    logic addr_bad;
    logic brcv;

    always_comb begin
        addr_bad = (sts_word[WORD_W-1:ADDR_LSB] != exp_addr);
        brcv     = sts_word[POS_BRCV];
        // mask XOR received bit flags a mismatch; the mask decides its class
        set_err  = (mask_bc ^ brcv) & ~mask_bc;
        fmt_err  = ((mask_bc ^ brcv) & mask_bc) | addr_bad;
    end
endmodule

// File: rtl/bc_status_checker.sv
module bc_status_checker
    import bcsc_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int ADDR_W    = 5,
    parameter int WC_W      = 5,
    parameter int POS_BUS   = 7,
    parameter int POS_TEST  = 5,
    parameter int POS_MASK  = 4,
    parameter int POS_MODE  = 2,
    parameter int POS_BCAST = 1,
    parameter int POS_RTRT  = 0,
    parameter int POS_BRCV  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msg_start,
    input  logic [WORD_W-1:0] ctrl_word,
    input  logic [ADDR_W-1:0] cmd_rt_addr,
    input  logic [ADDR_W-1:0] cmd_rt_addr2,
    input  logic [WC_W-1:0]   cmd_wc,
    input  logic              sts_valid,
    input  logic [WORD_W-1:0] sts_word,
    input  logic              msg_end,
    output logic              bus_a_o,
    output logic              selftest_o,
    output logic              mode_code_o,
    output logic [WC_W-1:0]   mode_type_o,
    output logic              done_o,
    output logic              sts_set_err_o,
    output logic              fmt_err_o
);
    bcsc_state_e state_q, state_d;
    msg_cfg_t    cfg_new, cfg_q;
    logic [ADDR_W-1:0] addr1_q, addr2_q, exp_addr;
    logic        acc_set_q, acc_set_d;
    logic        acc_fmt_q, acc_fmt_d;
    logic        accept;
    logic        ev_set, ev_fmt;

    bcsc_ctrl_decode #(
        .WORD_W(WORD_W), .POS_BUS(POS_BUS), .POS_TEST(POS_TEST),
        .POS_MASK(POS_MASK), .POS_MODE(POS_MODE),
        .POS_BCAST(POS_BCAST), .POS_RTRT(POS_RTRT)
    ) u_dec (
        .ctrl_word (ctrl_word),
        .cfg       (cfg_new)
    );

    // In an RT-to-RT transfer the transmitting terminal answers first
    assign exp_addr = (state_q == ST_WAIT_FIRST && cfg_q.rtrt) ? addr2_q : addr1_q;

    bcsc_sts_eval #(
        .WORD_W(WORD_W), .ADDR_W(ADDR_W), .POS_BRCV(POS_BRCV)
    ) u_eval (
        .sts_word (sts_word),
        .exp_addr (exp_addr),
        .mask_bc  (cfg_q.mask_bc),
        .set_err  (ev_set),
        .fmt_err  (ev_fmt)
    );

    // Next-state and error accumulation
    always_comb begin
        state_d   = state_q;
        acc_set_d = acc_set_q;
        acc_fmt_d = acc_fmt_q;
        accept    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (msg_start) begin
                    accept    = 1'b1;
                    acc_set_d = 1'b0;
                    acc_fmt_d = 1'b0;
                    state_d   = cfg_new.bcast ? ST_BCAST_OPEN : ST_WAIT_FIRST;
                end
            end
            ST_WAIT_FIRST: begin
                if (sts_valid) begin
                    acc_set_d = acc_set_q | ev_set;
                    acc_fmt_d = acc_fmt_q | ev_fmt;
                    if (!cfg_q.rtrt) begin
                        state_d = ST_REPORT;
                    end else if (msg_end) begin
                        acc_fmt_d = 1'b1;
                        state_d   = ST_REPORT;
                    end else begin
                        state_d = ST_WAIT_SECOND;
                    end
                end else if (msg_end) begin
                    acc_fmt_d = 1'b1;
                    state_d   = ST_REPORT;
                end
            end
            ST_WAIT_SECOND: begin
                if (sts_valid) begin
                    acc_set_d = acc_set_q | ev_set;
                    acc_fmt_d = acc_fmt_q | ev_fmt;
                    state_d   = ST_REPORT;
                end else if (msg_end) begin
                    acc_fmt_d = 1'b1;
                    state_d   = ST_REPORT;
                end
            end
            ST_BCAST_OPEN: begin
                if (sts_valid) acc_fmt_d = 1'b1;
                if (msg_end)   state_d   = ST_REPORT;
            end
            ST_REPORT: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and message context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cfg_q     <= '0;
            addr1_q   <= '0;
            addr2_q   <= '0;
            acc_set_q <= 1'b0;
            acc_fmt_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            acc_set_q <= acc_set_d;
            acc_fmt_q <= acc_fmt_d;
            if (accept) begin
                cfg_q   <= cfg_new;
                addr1_q <= cmd_rt_addr;
                addr2_q <= cmd_rt_addr2;
            end
        end
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_a_o       <= 1'b0;
            selftest_o    <= 1'b0;
            mode_code_o   <= 1'b0;
            mode_type_o   <= '0;
            done_o        <= 1'b0;
            sts_set_err_o <= 1'b0;
            fmt_err_o     <= 1'b0;
        end else begin
            if (accept) begin
                bus_a_o     <= cfg_new.bus_a;
                selftest_o  <= cfg_new.selftest;
                mode_code_o <= cfg_new.mode_code;
                mode_type_o <= cfg_new.mode_code ? cmd_wc : '0;
            end
            done_o        <= (state_d == ST_REPORT);
            sts_set_err_o <= (state_d == ST_REPORT) & acc_set_d;
            fmt_err_o     <= (state_d == ST_REPORT) & acc_fmt_d;
        end
    end
endmodule

// File: rtl/bcsc_checker.sv
module bcsc_checker
    import bcsc_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int POS_BUS = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              msg_start,
    input logic [WORD_W-1:0] ctrl_word,
    input logic              sts_valid,
    input logic              msg_end,
    input logic              bus_a_o,
    input logic              done_o,
    input logic              sts_set_err_o,
    input logic              fmt_err_o,
    input bcsc_state_e       state_q
);
    p_err_needs_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_set_err_o || fmt_err_o) |-> done_o);

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(sts_valid || msg_end));

    p_bus_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_start && state_q == ST_IDLE) |=> (bus_a_o == $past(ctrl_word[POS_BUS])));

    p_busy_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(msg_start && state_q == ST_IDLE) |=> $stable(bus_a_o));

    p_bcast_no_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BCAST_OPEN) |=> !sts_set_err_o);

    p_bcast_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BCAST_OPEN && msg_end) |=> done_o);
endmodule

bind bc_status_checker bcsc_checker #(.WORD_W(WORD_W), .POS_BUS(POS_BUS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .msg_start     (msg_start),
    .ctrl_word     (ctrl_word),
    .sts_valid     (sts_valid),
    .msg_end       (msg_end),
    .bus_a_o       (bus_a_o),
    .done_o        (done_o),
    .sts_set_err_o (sts_set_err_o),
    .fmt_err_o     (fmt_err_o),
    .state_q       (state_q)
);

// File: tb/sim_bc_status_checker.sv
`timescale 1ns/1ps
module sim_bc_status_checker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msg_start = 1'b0;
    logic [15:0] ctrl_word = '0;
    logic [4:0]  cmd_rt_addr = '0, cmd_rt_addr2 = '0, cmd_wc = '0;
    logic        sts_valid = 1'b0;
    logic [15:0] sts_word = '0;
    logic        msg_end = 1'b0;
    logic        bus_a_o, selftest_o, mode_code_o, done_o, sts_set_err_o, fmt_err_o;
    logic [4:0]  mode_type_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    bc_status_checker u0 (
        .clk(clk), .rst_n(rst_n), .msg_start(msg_start), .ctrl_word(ctrl_word),
        .cmd_rt_addr(cmd_rt_addr), .cmd_rt_addr2(cmd_rt_addr2), .cmd_wc(cmd_wc),
        .sts_valid(sts_valid), .sts_word(sts_word), .msg_end(msg_end),
        .bus_a_o(bus_a_o), .selftest_o(selftest_o), .mode_code_o(mode_code_o),
        .mode_type_o(mode_type_o), .done_o(done_o),
        .sts_set_err_o(sts_set_err_o), .fmt_err_o(fmt_err_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] mk_sts(input logic [4:0] addr, input logic brcv);
        return {addr, 6'b0, brcv, 4'b0};
    endfunction

    // Returns {set_err, fmt_err} for one message
    function automatic logic [1:0] model(input logic [15:0] cw, input logic [4:0] a1,
                                         input logic [4:0] a2, input int n,
                                         input logic [15:0] s0, input logic [15:0] s1);
        logic se = 0, fe = 0;
        int need;
        if (cw[1]) return {1'b0, n > 0};
        need = cw[0] ? 2 : 1;
        for (int i = 0; i < need && i < n; i++) begin
            logic [15:0] w = (i == 0) ? s0 : s1;
            logic [4:0]  ea = (cw[0] && i == 0) ? a2 : a1;
            if (w[15:11] != ea) fe = 1;
            if (cw[4] && !w[4]) fe = 1;
            if (!cw[4] && w[4]) se = 1;
        end
        if (n < need) fe = 1;
        return {se, fe};
    endfunction

    task automatic run_msg(input string req, input logic [15:0] cw, input logic [4:0] a1,
                           input logic [4:0] a2, input logic [4:0] wc, input int n,
                           input logic [15:0] s0, input logic [15:0] s1);
        logic [1:0] exp;
        int need, sent;
        exp = model(cw, a1, a2, n, s0, s1);
        need = cw[1] ? n : (cw[0] ? 2 : 1);
        sent = (n < need) ? n : need;
        @(negedge clk);
        msg_start = 1; ctrl_word = cw; cmd_rt_addr = a1; cmd_rt_addr2 = a2; cmd_wc = wc;
        @(posedge clk);
        @(negedge clk);
        msg_start = 0; ctrl_word = $urandom;
        check("R2", "bus_a", bus_a_o, cw[7]);
        check("R2", "selftest", selftest_o, cw[5]);
        check("R2", "mode_code", mode_code_o, cw[2]);
        check("R2", "mode_type", mode_type_o, cw[2] ? wc : 0);
        for (int i = 0; i < sent; i++) begin
            sts_valid = 1; sts_word = (i == 0) ? s0 : s1;
            @(posedge clk);
            @(negedge clk);
            sts_valid = 0;
            if (i < sent - 1 || cw[1] || sent < need)
                check(req, "done early", done_o, 0);
        end
        if (cw[1] || sent < need) begin
            msg_end = 1;
            @(posedge clk);
            @(negedge clk);
            msg_end = 0;
        end
        check(req, "done", done_o, 1);
        check(req, "sts_set_err", sts_set_err_o, exp[1]);
        check(req, "fmt_err", fmt_err_o, exp[0]);
        @(posedge clk);
        @(negedge clk);
        check("R9", "done pulse width", done_o, 0);
        check("R9", "err pulse width", sts_set_err_o | fmt_err_o, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1553));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "done", done_o, 0);
        check("R1", "bus_a", bus_a_o, 0);
        check("R1", "errors", sts_set_err_o | fmt_err_o, 0);
        check("R1", "mode_type", mode_type_o, 0);
        rst_n = 1;

        // R3 plain message, good response; R2 with noise in unused bits
        run_msg("R3", 16'hFF80, 5'd3, 5'd9, 5'd7, 1, mk_sts(5'd3, 0), 0);
        run_msg("R2", 16'h0024, 5'd3, 5'd9, 5'd17, 1, mk_sts(5'd3, 0), 0);
        // R4 mask rule: all four pairings
        run_msg("R4", 16'h0000, 5'd5, 5'd0, 5'd0, 1, mk_sts(5'd5, 1), 0);
        run_msg("R4", 16'h0010, 5'd5, 5'd0, 5'd0, 1, mk_sts(5'd5, 0), 0);
        run_msg("R4", 16'h0010, 5'd5, 5'd0, 5'd0, 1, mk_sts(5'd5, 1), 0);
        run_msg("R4", 16'h0000, 5'd5, 5'd0, 5'd0, 1, mk_sts(5'd5, 0), 0);
        // R5 address mismatch
        run_msg("R5", 16'h0080, 5'd5, 5'd0, 5'd0, 1, mk_sts(5'd6, 0), 0);
        // R6 RT-to-RT: good, first bad, second bad, status error on second
        run_msg("R6", 16'h0001, 5'd1, 5'd2, 5'd0, 2, mk_sts(5'd2, 0), mk_sts(5'd1, 0));
        run_msg("R6", 16'h0001, 5'd1, 5'd2, 5'd0, 2, mk_sts(5'd1, 0), mk_sts(5'd1, 0));
        run_msg("R6", 16'h0001, 5'd1, 5'd2, 5'd0, 2, mk_sts(5'd2, 0), mk_sts(5'd2, 0));
        run_msg("R6", 16'h0001, 5'd1, 5'd2, 5'd0, 2, mk_sts(5'd2, 0), mk_sts(5'd1, 1));
        // R7 broadcast with 0, 1, 2 stray statuses
        run_msg("R7", 16'h0002, 5'd31, 5'd0, 5'd0, 0, 0, 0);
        run_msg("R7", 16'h0012, 5'd31, 5'd0, 5'd0, 1, mk_sts(5'd31, 1), 0);
        run_msg("R7", 16'h0003, 5'd31, 5'd0, 5'd0, 2, mk_sts(5'd4, 1), mk_sts(5'd4, 1));
        // R8 missing responses
        run_msg("R8", 16'h0000, 5'd8, 5'd0, 5'd0, 0, 0, 0);
        run_msg("R8", 16'h0001, 5'd8, 5'd9, 5'd0, 1, mk_sts(5'd9, 0), 0);

        // R10 start while busy is ignored
        @(negedge clk);
        msg_start = 1; ctrl_word = 16'h0080; cmd_rt_addr = 5'd12;
        @(posedge clk);
        @(negedge clk);
        ctrl_word = 16'h0002; cmd_rt_addr = 5'd13;
        @(posedge clk);
        @(negedge clk);
        msg_start = 0;
        check("R10", "bus_a kept", bus_a_o, 1);
        check("R10", "done", done_o, 0);
        sts_valid = 1; sts_word = mk_sts(5'd12, 0);
        @(posedge clk);
        @(negedge clk);
        sts_valid = 0;
        check("R10", "done on original message", done_o, 1);
        check("R10", "fmt_err", fmt_err_o, 0);
        @(posedge clk);

        // Random mix
        for (int k = 0; k < 400; k++) begin
            logic [15:0] cw = $urandom;
            logic [4:0]  a1 = $urandom, a2 = $urandom;
            logic [15:0] s0, s1;
            int n;
            s0 = ($urandom % 4 != 0) ? mk_sts(cw[0] ? a2 : a1, $urandom) : 16'($urandom);
            s1 = ($urandom % 4 != 0) ? mk_sts(a1, $urandom) : 16'($urandom);
            if (cw[1]) n = ($urandom % 3);
            else n = ($urandom % 6 == 0) ? 0 : 2;
            run_msg(cw[1] ? "R7" : (cw[0] ? "R6" : "R4"), cw, a1, a2, 5'($urandom), n, s0, s1);
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule